// File: doc/BRIEF.md
# Multi-channel reloading timer bank

This peripheral holds three down-counting interval timers and one 40-bit up-counter behind a plain 32-bit register port. Each register port access uses an address, a write strobe and write data, and read data comes back in the same cycle. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. All three share one control format. Each channel counts on one of two externally prescaled tick strobes. When it passes zero it raises a latched interrupt. It then either reloads its programmed value or wraps to all ones.

The 40-bit counter advances on its own tick strobe once software sets its enable flag. It never interrupts, so it suits a time base for measuring elapsed time. Tick strobes arrive as single-cycle enables, because prescaling happens outside the block. The register port has no handshake: every write completes in the cycle it is presented.

The block has no streaming data path, so no port uses valid/ready. A channel programmed with a reload value N produces one interrupt every N+1 ticks, so software writes the load value as (tick rate / wanted rate) - 1.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero, every counter is stopped and all three interrupt lines are low.
- R2: The channel register groups start at byte offsets 0x00, 0x20 and 0x80. Within a group, +0x0 is the reload value, +0x4 is the live count (read-only), +0x8 is control and +0xC is the interrupt clear (reads zero). The counter sits at 0x60 (low word, read-only) and 0x64 (high word). Any other address reads zero and ignores writes.
- R3: Channels 0 and 1 keep only bits [15:0] of a written reload value and read zero above them. Channel 2 keeps all 32 bits.
- R4: In the control word, bit 7 enables counting and bit 6 selects reload-on-underflow. Bit 3 set selects the fast tick, and bit 3 clear selects the slow tick. Every other control bit reads zero.
- R5: An enabled channel decrements by one on each cycle in which its selected tick strobe is high. A disabled channel, or a strobe on the unselected tick, leaves the count unchanged.
- R6: With reload selected, a tick at count zero loads the reload value, so the interrupt period is reload + 1 ticks. A reload value written while the channel runs takes effect at the next underflow.
- R7: With reload not selected, a tick at count zero wraps the count to all ones for the channel's width.
- R8: A tick at count zero sets the channel's interrupt line one cycle later. The line stays high until cleared. An underflow in the same cycle as a clear write leaves the line high.
- R9: A write of any data value to a channel's clear register drops that channel's interrupt line on the next cycle.
- R10: A reload value written while the channel is disabled also becomes the live count. Written while enabled, it leaves the live count alone.
- R11: Writing 0x64 sets the counter enable from data bit 8. While enabled, the counter adds one per free-tick strobe. Reading 0x64 returns count bits [39:32] in bits [7:0] and the enable flag in bit 8. Writes to 0x60 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_slow | input | 1 | Slow tick strobe, one cycle wide |
| tick_fast | input | 1 | Fast tick strobe, one cycle wide |
| tick_free | input | 1 | Tick strobe for the 40-bit counter |
| irq | output | 3 | Latched interrupt per channel, bit n for channel n |

## Verification
The assertions assume that tick strobes and register writes are synchronous to clk. They also assume that a clear write and an underflow of the same channel may coincide, and that the wrap of the 40-bit counter follows ordinary modulo arithmetic. The stimulus changes every input shortly after a rising edge and holds a write for exactly one cycle. It deliberately lines up a clear write with an underflow, rewrites a running channel's reload value, and sends strobes on the unselected tick to check that they are ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NCH = 3;
  localparam int DATA_W = 32;

  // register offsets inside one channel group
  localparam int OFS_LOAD = 'h0;
  localparam int OFS_VAL  = 'h4;
  localparam int OFS_CTRL = 'h8;
  localparam int OFS_CLR  = 'hC;

  // 40-bit counter words
  localparam int FREE_LO = 'h60;
  localparam int FREE_HI = 'h64;
  localparam int FREE_EN_BIT = 8;

  // control word bit positions
  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } tmr_ctrl_t;

  function automatic int ch_base(int idx);
    case (idx)
      0:       return 'h00;
      1:       return 'h20;
      default: return 'h80;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(tmr_ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_EN]   = c.en;
    w[BIT_PER]  = c.periodic;
    w[BIT_FAST] = c.fast;
    return w;
  endfunction

endpackage

// File: rtl/tmr_interval.sv
module tmr_interval
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_wr,
  input  logic             ctrl_wr,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] load_in,
  input  tmr_ctrl_t        ctrl_in,
  input  logic             tick_slow,
  input  logic             tick_fast,
  output logic [WIDTH-1:0] load_o,
  output logic [WIDTH-1:0] cnt_o,
  output tmr_ctrl_t        ctrl_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] load_q;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  tmr_ctrl_t        ctrl_q;
  logic             irq_q;
  logic             tick_sel;
  logic             step;
  logic             at_zero;
  logic             underflow;

  assign tick_sel  = ctrl_q.fast ? tick_fast : tick_slow;
  assign step      = ctrl_q.en & tick_sel;
  assign at_zero   = (cnt_q == '0);
  assign underflow = step & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (at_zero) cnt_d = ctrl_q.periodic ? load_q : '1;
      else         cnt_d = cnt_q - 1'b1;
    end else if (load_wr && !ctrl_q.en) begin
      cnt_d = load_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (load_wr) load_q <= load_in;
      if (ctrl_wr) ctrl_q <= ctrl_in;
      if (underflow)   irq_q <= 1'b1;
      else if (clr_wr) irq_q <= 1'b0;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o.en && !load_wr) |=> $stable(cnt_o));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl_o.periodic) |=> (cnt_o == $past(load_o)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctrl_o.periodic) |=> (&cnt_o));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq_o);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !underflow) |=> !irq_o);

  assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && !ctrl_o.en) |=> (cnt_o == $past(load_in)));

endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             en_in,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             en_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_q && tick) cnt_q <= cnt_q + 1'b1;
      if (cfg_wr)       en_q  <= en_in;
    end
  end

  assign count_o = cnt_q;
  assign en_o    = en_q;

  assert_free_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && tick) |=> (count_o == $past(count_o) + 1'b1));

  assert_free_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_o && tick) |=> $stable(count_o));

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FREE_W = 40
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NCH-1:0][DATA_W-1:0]  load_v,
  input  logic [NCH-1:0][DATA_W-1:0]  cnt_v,
  input  logic [NCH-1:0][DATA_W-1:0]  ctrl_v,
  input  logic [FREE_W-1:0]           free_cnt,
  input  logic                        free_en,
  output logic [DATA_W-1:0]           rdata
);

  localparam int HI_W = FREE_W - DATA_W;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(ch_base(i) + OFS_LOAD)) rdata = load_v[i];
      if (addr == ADDR_W'(ch_base(i) + OFS_VAL))  rdata = cnt_v[i];
      if (addr == ADDR_W'(ch_base(i) + OFS_CTRL)) rdata = ctrl_v[i];
    end
    if (addr == ADDR_W'(FREE_LO)) rdata = free_cnt[DATA_W-1:0];
    if (addr == ADDR_W'(FREE_HI)) begin
      rdata = DATA_W'(free_cnt[FREE_W-1:DATA_W]);
      rdata[FREE_EN_BIT] = free_en;
    end
  end

  initial begin
    assert_hi_fits_R11: assert (HI_W > 0 && HI_W <= FREE_EN_BIT)
      else $error("counter high word overlaps the enable flag");
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              tick_free,
  output logic [2:0]        irq
);

  logic [NCH-1:0][DATA_W-1:0] load_v;
  logic [NCH-1:0][DATA_W-1:0] cnt_v;
  logic [NCH-1:0][DATA_W-1:0] ctrl_v;
  logic [FREE_W-1:0]          free_cnt;
  logic                       free_en;
  logic                       free_wr;
  tmr_ctrl_t                  ctrl_in;

  assign ctrl_in = '{en:       bus_wdata[BIT_EN],
                     periodic: bus_wdata[BIT_PER],
                     fast:     bus_wdata[BIT_FAST]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int W    = (g == NCH - 1) ? WIDE_W : NARROW_W;
    localparam int BASE = ch_base(g);

    logic      load_wr, ctrl_wr, clr_wr;
    logic [W-1:0] load_o, cnt_o;
    tmr_ctrl_t ctrl_o;

    assign load_wr = bus_we && (bus_addr == ADDR_W'(BASE + OFS_LOAD));
    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(BASE + OFS_CTRL));
    assign clr_wr  = bus_we && (bus_addr == ADDR_W'(BASE + OFS_CLR));

    tmr_interval #(.WIDTH(W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_wr   (load_wr),
      .ctrl_wr   (ctrl_wr),
      .clr_wr    (clr_wr),
      .load_in   (bus_wdata[W-1:0]),
      .ctrl_in   (ctrl_in),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .load_o    (load_o),
      .cnt_o     (cnt_o),
      .ctrl_o    (ctrl_o),
      .irq_o     (irq[g])
    );

    assign load_v[g] = DATA_W'(load_o);
    assign cnt_v[g]  = DATA_W'(cnt_o);
    assign ctrl_v[g] = ctrl_word(ctrl_o);
  end

  assign free_wr = bus_we && (bus_addr == ADDR_W'(FREE_HI));

  tmr_freerun #(.CNT_W(FREE_W)) i_free (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (free_wr),
    .en_in   (bus_wdata[FREE_EN_BIT]),
    .tick    (tick_free),
    .count_o (free_cnt),
    .en_o    (free_en)
  );

  tmr_rdmux #(.ADDR_W(ADDR_W), .FREE_W(FREE_W)) i_rdmux (
    .addr     (bus_addr),
    .load_v   (load_v),
    .cnt_v    (cnt_v),
    .ctrl_v   (ctrl_v),
    .free_cnt (free_cnt),
    .free_en  (free_en),
    .rdata    (bus_rdata)
  );

  assert_irq_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        tick_free = 1'b0;
  logic [2:0]  irq;

  always #2 clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .tick_free (tick_free),
    .irq       (irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference model
  int unsigned m_load[3];
  int unsigned m_cnt[3];
  bit          m_en[3], m_per[3], m_fast[3], m_irq[3];
  longint unsigned m_free;
  bit          m_fen;

  function automatic int unsigned base_of(int c);
    return (c == 0) ? 32'h00 : (c == 1) ? 32'h20 : 32'h80;
  endfunction

  function automatic int unsigned mask_of(int c);
    return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    for (int c = 0; c < 3; c++) begin
      if (a == 8'(base_of(c)))      r = m_load[c];
      if (a == 8'(base_of(c) + 4))  r = m_cnt[c];
      if (a == 8'(base_of(c) + 8))  r = {24'd0, m_en[c], m_per[c], 2'b00, m_fast[c], 3'b000};
    end
    if (a == 8'h60) r = m_free[31:0];
    if (a == 8'h64) r = {23'd0, m_fen, m_free[39:32]};
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_load[c] = 0; m_cnt[c] = 0; m_en[c] = 0; m_per[c] = 0; m_fast[c] = 0; m_irq[c] = 0;
      end
      m_free = 0; m_fen = 0;
    end else begin
      for (int c = 0; c < 3; c++) begin
        bit tk;
        bit uf;
        tk = m_en[c] && (m_fast[c] ? tick_fast : tick_slow);
        uf = tk && (m_cnt[c] == 0);
        if (tk) m_cnt[c] = (m_cnt[c] == 0) ? (m_per[c] ? m_load[c] : mask_of(c)) : m_cnt[c] - 1;
        else if (bus_we && bus_addr == 8'(base_of(c)) && !m_en[c]) m_cnt[c] = bus_wdata & mask_of(c);
        if (uf) m_irq[c] = 1;
        else if (bus_we && bus_addr == 8'(base_of(c) + 12)) m_irq[c] = 0;
        if (bus_we && bus_addr == 8'(base_of(c))) m_load[c] = bus_wdata & mask_of(c);
        if (bus_we && bus_addr == 8'(base_of(c) + 8)) begin
          m_en[c] = bus_wdata[7]; m_per[c] = bus_wdata[6]; m_fast[c] = bus_wdata[3];
        end
      end
      if (m_fen && tick_free) m_free = (m_free + 1) & 64'hFF_FFFF_FFFF;
      if (bus_we && bus_addr == 8'h64) m_fen = bus_wdata[8];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2", bus_rdata, model_read(bus_addr), "model readback");
      check("R8", 32'(irq), 32'({m_irq[2], m_irq[1], m_irq[0]}), "model irq");
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp, $sformatf("read %h", a));
  endtask

  task automatic chk_irq(logic [2:0] exp, string req);
    @(negedge clk);
    check(req, 32'(irq), 32'(exp), "irq lines");
  endtask

  task automatic pulse(int which, int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (which == 0) tick_slow = 1'b1;
      if (which == 1) tick_fast = 1'b1;
      if (which == 2) tick_free = 1'b1;
      @(posedge clk); #1;
      tick_slow = 1'b0; tick_fast = 1'b0; tick_free = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1");
    rd(8'h04, 32'h0, "R1");
    rd(8'h88, 32'h0, "R1");
    rd(8'h64, 32'h0, "R1");
    chk_irq(3'b000, "R1");

    // R3 and R10: widths, load into idle counter
    wr(8'h00, 32'h0001_2345);
    rd(8'h00, 32'h0000_2345, "R3");
    rd(8'h04, 32'h0000_2345, "R10");
    wr(8'h80, 32'hDEAD_BEEF);
    rd(8'h84, 32'hDEAD_BEEF, "R3");

    // R2 unmapped and read-only locations
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R2");
    wr(8'h04, 32'h0000_0055);
    rd(8'h04, 32'h0000_2345, "R2");
    rd(8'h0C, 32'h0, "R2");

    // R4 control bits
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h0000_00FF);
    rd(8'h08, 32'h0000_00C8, "R4");
    wr(8'h08, 32'h0000_00C0);
    rd(8'h08, 32'h0000_00C0, "R4");

    // R5 unselected tick ignored, selected tick decrements
    pulse(1, 2);
    rd(8'h04, 32'd3, "R5");
    pulse(0, 1);
    rd(8'h04, 32'd2, "R5");
    pulse(0, 2);
    rd(8'h04, 32'd0, "R5");
    chk_irq(3'b000, "R8");

    // R6 reload after load+1 ticks, R8 latch
    pulse(0, 1);
    rd(8'h04, 32'd3, "R6");
    chk_irq(3'b001, "R8");

    // R9 clear with zero data
    wr(8'h0C, 32'h0);
    chk_irq(3'b000, "R9");

    // R10 load while running leaves count; R6 new load used at underflow
    wr(8'h00, 32'd7);
    rd(8'h04, 32'd3, "R10");
    pulse(0, 4);
    rd(8'h04, 32'd7, "R6");
    chk_irq(3'b001, "R8");
    wr(8'h0C, 32'hFFFF_FFFF);
    chk_irq(3'b000, "R9");
    wr(8'h08, 32'h0);

    // R7 wrap in non-reload mode, 16-bit channel
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h0000_0088);
    pulse(1, 1);
    rd(8'h24, 32'd0, "R7");
    pulse(1, 1);
    rd(8'h24, 32'h0000_FFFF, "R7");
    chk_irq(3'b010, "R8");
    wr(8'h2C, 32'h0000_ABCD);
    chk_irq(3'b000, "R9");
    wr(8'h28, 32'h0);

    // R8 clear coinciding with underflow; R7 32-bit wrap
    wr(8'h80, 32'h0);
    rd(8'h84, 32'h0, "R10");
    wr(8'h88, 32'h0000_0088);
    @(posedge clk); #1;
    bus_addr = 8'h8C; bus_we = 1'b1; bus_wdata = 32'h1; tick_fast = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; tick_fast = 1'b0;
    chk_irq(3'b100, "R8");
    rd(8'h84, 32'hFFFF_FFFF, "R7");
    wr(8'h8C, 32'h0);
    chk_irq(3'b000, "R9");
    wr(8'h88, 32'h0);

    // R11 free-running counter
    pulse(2, 3);
    rd(8'h60, 32'd0, "R11");
    wr(8'h64, 32'h0000_0100);
    rd(8'h64, 32'h0000_0100, "R11");
    pulse(2, 5);
    rd(8'h60, 32'd5, "R11");
    wr(8'h60, 32'h0000_FFFF);
    rd(8'h60, 32'd5, "R11");
    wr(8'h64, 32'h0);
    pulse(2, 2);
    rd(8'h60, 32'd5, "R11");
    rd(8'h64, 32'h0, "R11");

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule